// File: doc/BRIEF.md
# Filter Configuration Word Loader

This block takes the configuration of a two-dimensional image filter over a single 12-bit word bus and turns it into write strobes for the filter's coefficient memories and register files. A transfer begins with an address word, which is flagged by a load strobe. The address word names a target kind, a filter direction (horizontal or vertical) and an index. Payload words follow it, one per clock. Their number depends on the target kind.

Coefficient sets span eight banks. One transfer writes the same address in all eight banks at once, with one 12-bit value per bank. The other targets are configuration, select, round and limit registers, and each exists separately for the horizontal and the vertical direction. A write is issued only in the cycle that carries the final payload word, so the downstream storage captures it on that clock edge.

Two hold inputs, one per direction, freeze a transfer of that direction in place. A frozen transfer resumes from where it stopped. A load strobe that arrives in the middle of a transfer discards the pending write and starts a new transfer.

Top module: `cfg_load_if`

## Requirements
- R1: An address word is taken only while `ld` is high. Bits [11:9] give the target code: 0 coefficient set, 1 configuration, 2 round, 3 select, 4 limit. Bit 8 gives the direction (0 horizontal, 1 vertical), and bits [7:0] give the index. A word with `ld` low while idle is ignored, and so is an address word with code 5, 6 or 7.
- R2: A coefficient-set transfer takes eight payload words, for banks 0 to 7 in order. Bank k's value appears on `coef_data[12k+11:12k]`. All eight values are written to `coef_addr` equal to the index.
- R3: A configuration or select transfer takes one payload word. That word appears on `reg_data[11:0]`, with `reg_data[31:12]` at zero.
- R4: A round transfer takes four payload words. Each word contributes its bits [7:0], first word most significant, forming the 32-bit `reg_data`. Bits [11:8] of these words have no effect.
- R5: A limit transfer takes two payload words, first the lower and then the upper limit. The lower limit appears on `reg_data[11:0]`, the upper on `reg_data[23:12]`, and `reg_data[31:24]` is zero.
- R6: `coef_we` or `reg_we` is high for exactly the one cycle in which the final payload word is on the bus, and never both at once. `reg_kind`, `reg_dir` and `reg_idx` (or `coef_dir` and `coef_addr`) reflect the address word. Afterwards the loader is idle.
- R7: While `hold_h` is high, a horizontal transfer, or a horizontal address word while idle, ignores the bus (including `ld`) and issues no write. The transfer continues from the same point once `hold_h` falls.
- R8: `hold_v` does the same for vertical transfers.
- R9: The hold input of the other direction has no effect on a transfer.
- R10: An unheld `ld` in the middle of a transfer drops the pending write and decodes that word as a new address word. If its code is invalid, the loader returns to idle.
- R11: During and right after reset the loader is idle and both write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Marks the current word as an address word |
| din | input | 12 | Word bus |
| hold_h | input | 1 | Freezes horizontal transfers |
| hold_v | input | 1 | Freezes vertical transfers |
| coef_we | output | 1 | Coefficient-set write strobe |
| coef_dir | output | 1 | Direction of the coefficient set |
| coef_addr | output | 8 | Coefficient-set address |
| coef_data | output | 96 | Eight bank values, bank k at [12k+11:12k] |
| reg_we | output | 1 | Register write strobe |
| reg_kind | output | 3 | Target code of the register write |
| reg_dir | output | 1 | Direction of the register write |
| reg_idx | output | 8 | Register index |
| reg_data | output | 32 | Register value |

## Verification
The checker watches every cycle for the following:
- the two strobes never overlap;
- a strobe only comes after exactly the number of accepted payload words that the target code demands, counted independently;
- a held transfer keeps its progress and writes nothing;
- a hold on the other direction never stalls a transfer;
- a mid-transfer strobe restarts the count;
- the loader is idle after each write.

Only the bench scenarios can show that payload values land in the right bank positions and byte order, with the right index and direction. They also show that held and ignored bus words leave the written data untouched, and that an aborted transfer leaves no trace. The bench shows these by sweeping every index in both directions for each target kind.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int TGT_W = 3;

  typedef enum logic [TGT_W-1:0] {
    TGT_COEF  = 3'd0,
    TGT_CFG   = 3'd1,
    TGT_ROUND = 3'd2,
    TGT_SEL   = 3'd3,
    TGT_LIMIT = 3'd4
  } tgt_e;

  function automatic logic tgt_valid(input logic [TGT_W-1:0] code);
    return code <= TGT_LIMIT;
  endfunction

  // number of payload words following the address word
  function automatic logic [31:0] payload_len(input logic [TGT_W-1:0] code,
                                              input int unsigned nbank);
    case (code)
      TGT_COEF:  return nbank;
      TGT_ROUND: return 32'd4;
      TGT_LIMIT: return 32'd2;
      default:   return 32'd1;
    endcase
  endfunction

  // round value: shift in one byte, first byte ends up most significant
  function automatic logic [31:0] round_push(input logic [31:0] acc,
                                             input logic [7:0] b);
    return {acc[23:0], b};
  endfunction
endpackage

// File: rtl/cfgld_decode.sv
module cfgld_decode
  import cfgld_pkg::*;
#(
  parameter int DW = 12,
  parameter int IW = 8
) (
  input  logic [DW-1:0]    word,
  output logic [TGT_W-1:0] tgt,
  output logic             dir,
  output logic [IW-1:0]    idx,
  output logic             valid
);
  assign tgt   = word[DW-1 -: TGT_W];
  assign dir   = word[IW];
  assign idx   = word[IW-1:0];
  assign valid = tgt_valid(tgt);
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int IW    = 8,
  parameter int NBANK = 8,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             hold_h,
  input  logic             hold_v,
  input  logic             dec_valid,
  input  logic [TGT_W-1:0] dec_tgt,
  input  logic             dec_dir,
  input  logic [IW-1:0]    dec_idx,
  output logic             busy,
  output logic [TGT_W-1:0] tgt,
  output logic             dir,
  output logic [IW-1:0]    idx,
  output logic [CW-1:0]    cnt,
  output logic             accept,
  output logic             start,
  output logic             data_ev,
  output logic             last
);
  logic             busy_q;
  logic [TGT_W-1:0] tgt_q;
  logic             dir_q;
  logic [IW-1:0]    idx_q;
  logic [CW-1:0]    cnt_q;
  logic             cur_dir;
  logic [31:0]      cnt_ext;

  assign cur_dir = busy_q ? dir_q : dec_dir;
  assign accept  = cur_dir ? !hold_v : !hold_h;
  assign start   = accept && ld && dec_valid;
  assign data_ev = accept && busy_q && !ld;
  assign cnt_ext = {{(32-CW){1'b0}}, cnt_q};
  assign last    = data_ev && (cnt_ext == payload_len(tgt_q, NBANK) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tgt_q  <= '0;
      dir_q  <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      tgt_q  <= dec_tgt;
      dir_q  <= dec_dir;
      idx_q  <= dec_idx;
      cnt_q  <= '0;
    end else if (accept && ld) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (last) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (data_ev) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign tgt  = tgt_q;
  assign dir  = dir_q;
  assign idx  = idx_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/cfgld_assemble.sv
module cfgld_assemble
  import cfgld_pkg::*;
#(
  parameter int DW    = 12,
  parameter int NBANK = 8,
  parameter int RW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_ev,
  input  logic [TGT_W-1:0]    tgt,
  input  logic [DW-1:0]       din,
  output logic [NBANK*DW-1:0] coef_data,
  output logic [RW-1:0]       reg_data
);
  localparam int CWID = NBANK * DW;

  logic [CWID-1:0] coef_q;
  logic [RW-1:0]   rnd_q;
  logic [DW-1:0]   lim_q;

  // newest word enters at the top; after NBANK words bank 0 sits at the bottom
  assign coef_data = {din, coef_q[CWID-1:DW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_q <= '0;
      rnd_q  <= '0;
      lim_q  <= '0;
    end else if (data_ev) begin
      case (tgt)
        TGT_COEF:  coef_q <= coef_data;
        TGT_ROUND: rnd_q  <= round_push(rnd_q, din[7:0]);
        TGT_LIMIT: lim_q  <= din;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (tgt)
      TGT_ROUND: reg_data = round_push(rnd_q, din[7:0]);
      TGT_LIMIT: reg_data = {{(RW-2*DW){1'b0}}, din, lim_q};
      default:   reg_data = {{(RW-DW){1'b0}}, din};
    endcase
  end
endmodule

// File: rtl/cfg_load_if.sv
module cfg_load_if
  import cfgld_pkg::*;
#(
  parameter int DW    = 12,
  parameter int IW    = 8,
  parameter int NBANK = 8,
  parameter int RW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic [DW-1:0]       din,
  input  logic                hold_h,
  input  logic                hold_v,
  output logic                coef_we,
  output logic                coef_dir,
  output logic [IW-1:0]       coef_addr,
  output logic [NBANK*DW-1:0] coef_data,
  output logic                reg_we,
  output logic [TGT_W-1:0]    reg_kind,
  output logic                reg_dir,
  output logic [IW-1:0]       reg_idx,
  output logic [RW-1:0]       reg_data
);
  localparam int CW = $clog2(NBANK + 1);

  logic             dec_valid;
  logic [TGT_W-1:0] dec_tgt;
  logic             dec_dir;
  logic [IW-1:0]    dec_idx;

  // named internal events, observed by the checker
  logic             seq_busy;
  logic [TGT_W-1:0] seq_tgt;
  logic             seq_dir;
  logic [IW-1:0]    seq_idx;
  logic [CW-1:0]    seq_cnt;
  logic             evt_accept;
  logic             evt_start;
  logic             evt_data;
  logic             evt_last;

  cfgld_decode #(.DW(DW), .IW(IW)) u_dec (
    .word (din),
    .tgt  (dec_tgt),
    .dir  (dec_dir),
    .idx  (dec_idx),
    .valid(dec_valid)
  );

  cfgld_seq #(.IW(IW), .NBANK(NBANK), .CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .hold_h   (hold_h),
    .hold_v   (hold_v),
    .dec_valid(dec_valid),
    .dec_tgt  (dec_tgt),
    .dec_dir  (dec_dir),
    .dec_idx  (dec_idx),
    .busy     (seq_busy),
    .tgt      (seq_tgt),
    .dir      (seq_dir),
    .idx      (seq_idx),
    .cnt      (seq_cnt),
    .accept   (evt_accept),
    .start    (evt_start),
    .data_ev  (evt_data),
    .last     (evt_last)
  );

  cfgld_assemble #(.DW(DW), .NBANK(NBANK), .RW(RW)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_ev  (evt_data),
    .tgt      (seq_tgt),
    .din      (din),
    .coef_data(coef_data),
    .reg_data (reg_data)
  );

  assign coef_we   = evt_last && (seq_tgt == TGT_COEF);
  assign reg_we    = evt_last && (seq_tgt != TGT_COEF);
  assign coef_dir  = seq_dir;
  assign coef_addr = seq_idx;
  assign reg_kind  = seq_tgt;
  assign reg_dir   = seq_dir;
  assign reg_idx   = seq_idx;
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk
  import cfgld_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld,
  input logic             hold_h,
  input logic             hold_v,
  input logic             seq_busy,
  input logic [TGT_W-1:0] seq_tgt,
  input logic             seq_dir,
  input logic [CW-1:0]    seq_cnt,
  input logic             coef_we,
  input logic             reg_we
);
  logic        own_hold;
  logic        other_hold;
  logic [31:0] words_seen;

  assign own_hold   = seq_dir ? hold_v : hold_h;
  assign other_hold = seq_dir ? hold_h : hold_v;

  // independent count of payload words taken since the last address word
  always_ff @(posedge clk) begin
    if (!rst_n || !seq_busy) words_seen <= '0;
    else if (!own_hold && ld) words_seen <= '0;
    else if (!own_hold) words_seen <= words_seen + 32'd1;
  end

  AST_EXCL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !(coef_we && reg_we)); // R6

  AST_WRITE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_we || reg_we) |-> seq_busy && (words_seen + 32'd1 == payload_len(seq_tgt, NBANK))); // R6

  AST_IDLE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_we || reg_we) |=> !seq_busy); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && own_hold) |=> seq_busy && $stable(seq_cnt) && $stable(seq_tgt) && $stable(seq_dir)); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && own_hold) |-> !coef_we && !reg_we); // R8

  AST_OTHER_HOLD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && other_hold && !own_hold && !ld) |=> !seq_busy || (seq_cnt == $past(seq_cnt) + 1'b1)); // R9

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !own_hold && ld) |=> seq_cnt == '0); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !seq_busy); // R11
endmodule

bind cfg_load_if cfgld_chk #(.NBANK(NBANK), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ld      (ld),
  .hold_h  (hold_h),
  .hold_v  (hold_v),
  .seq_busy(seq_busy),
  .seq_tgt (seq_tgt),
  .seq_dir (seq_dir),
  .seq_cnt (seq_cnt),
  .coef_we (coef_we),
  .reg_we  (reg_we)
);

// File: tb/sim_cfg_load_if.sv
`timescale 1ns/100ps
module sim_cfg_load_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic [11:0] din = '0;
  logic        hold_h = 1'b0;
  logic        hold_v = 1'b0;
  logic        coef_we, coef_dir, reg_we, reg_dir;
  logic [7:0]  coef_addr, reg_idx;
  logic [95:0] coef_data;
  logic [2:0]  reg_kind;
  logic [31:0] reg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_load_if u0 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .din(din), .hold_h(hold_h), .hold_v(hold_v),
    .coef_we(coef_we), .coef_dir(coef_dir), .coef_addr(coef_addr), .coef_data(coef_data),
    .reg_we(reg_we), .reg_kind(reg_kind), .reg_dir(reg_dir), .reg_idx(reg_idx),
    .reg_data(reg_data)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one word after the rising edge; return at the falling edge
  task automatic put(input logic l, input logic [11:0] d, input logic hh, input logic hv);
    @(posedge clk); #1;
    ld = l; din = d; hold_h = hh; hold_v = hv;
    @(negedge clk);
  endtask

  function automatic logic [11:0] wgen(input int a, input int k, input int s);
    return 12'((a * 173 + k * 389 + s * 59 + 7) % 4096);
  endfunction

  function automatic int plen(input int t);
    return (t == 0) ? 8 : (t == 2) ? 4 : (t == 4) ? 2 : 1;
  endfunction

  function automatic logic [11:0] addr_word(input int t, input int d, input int i);
    return 12'(t * 512 + d * 256 + i);
  endfunction

  // expected register value, built from the requirement text
  function automatic logic [31:0] exp_reg(input int t, input logic [11:0] w [8]);
    if (t == 2) return {w[0][7:0], w[1][7:0], w[2][7:0], w[3][7:0]};
    if (t == 4) return 32'(w[1]) * 32'd4096 + 32'(w[0]);
    return 32'(w[0]);
  endfunction

  task automatic check_write(input int t, input int d, input int i, input logic [11:0] w [8], input string tag);
    logic [95:0] ec;
    if (t == 0) begin
      for (int k = 0; k < 8; k++) ec[12*k +: 12] = w[k];
      chk(coef_we && !reg_we, "R6 coef strobe", {coef_we, reg_we}, 2'b10);
      chk(coef_addr == 8'(i) && coef_dir == 1'(d), "R1 coef index/dir", {coef_dir, coef_addr}, 9'(d * 256 + i));
      chk(coef_data == ec, {tag, " R2 coef data"}, coef_data, ec);
    end else begin
      chk(reg_we && !coef_we, "R6 reg strobe", {coef_we, reg_we}, 2'b01);
      chk(reg_kind == 3'(t) && reg_idx == 8'(i) && reg_dir == 1'(d), "R1 reg target",
          {reg_kind, reg_dir, reg_idx}, 12'(t * 512 + d * 256 + i));
      chk(reg_data == exp_reg(t, w), (t == 2) ? {tag, " R4 round"} : (t == 4) ? {tag, " R5 limit"} : {tag, " R3 single"},
          reg_data, exp_reg(t, w));
    end
  endtask

  // plain transfer without holds
  task automatic load(input int t, input int d, input int i, input int s);
    logic [11:0] w [8];
    bit early;
    int n;
    n = plen(t);
    for (int k = 0; k < 8; k++) w[k] = wgen(i, k, s + t);
    put(1'b1, addr_word(t, d, i), 1'b0, 1'b0);
    early = coef_we || reg_we;
    for (int k = 0; k < n - 1; k++) begin
      put(1'b0, w[k], 1'b0, 1'b0);
      early |= coef_we || reg_we;
    end
    chk(!early, "R6 no early write", early, 1'b0);
    put(1'b0, w[n-1], 1'b0, 1'b0);
    check_write(t, d, i, w, "sweep");
  endtask

  initial begin
    logic [11:0] w [8];
    bit any;
    repeat (3) @(negedge clk);
    chk(!coef_we && !reg_we, "R11 strobes low in reset", {coef_we, reg_we}, 2'b00);
    @(posedge clk); #1; rst_n = 1'b1;
    put(1'b0, 12'h00A, 1'b0, 1'b0);
    chk(!coef_we && !reg_we, "R11 idle after reset", {coef_we, reg_we}, 2'b00);

    // R1: idle words without ld, and invalid codes, are ignored
    any = 0;
    put(1'b0, addr_word(1, 0, 3), 1'b0, 1'b0); any |= coef_we || reg_we;
    put(1'b0, 12'h123, 1'b0, 1'b0);            any |= coef_we || reg_we;
    for (int c = 5; c < 8; c++) begin
      put(1'b1, addr_word(c, 0, 1), 1'b0, 1'b0); any |= coef_we || reg_we;
      put(1'b0, 12'h456, 1'b0, 1'b0);            any |= coef_we || reg_we;
    end
    chk(!any, "R1 ignored words/invalid codes", any, 1'b0);

    // full sweeps over every index, both directions, every target kind
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 256; i++)
        for (int t = 0; t < 5; t++)
          load(t, d, i, d * 3);

    // R6: loader idle after a write: a data word alone does nothing
    load(3, 0, 7, 11);
    put(1'b0, 12'hFFF, 1'b0, 1'b0);
    chk(!coef_we && !reg_we, "R6 idle after write", {coef_we, reg_we}, 2'b00);

    // R7 + R9: horizontal coefficient load held mid-way, vertical hold toggling
    for (int k = 0; k < 8; k++) w[k] = wgen(5, k, 40);
    any = 0;
    put(1'b1, addr_word(0, 0, 5), 1'b0, 1'b1); any |= coef_we || reg_we;
    for (int k = 0; k < 3; k++) begin put(1'b0, w[k], 1'b0, 1'(k)); any |= coef_we || reg_we; end
    put(1'b1, addr_word(1, 0, 9), 1'b1, 1'b0); any |= coef_we || reg_we;
    put(1'b0, 12'hABC, 1'b1, 1'b1);            any |= coef_we || reg_we;
    put(1'b0, 12'h777, 1'b1, 1'b0);            any |= coef_we || reg_we;
    chk(!any, "R7 no write while held", any, 1'b0);
    any = 0;
    for (int k = 3; k < 7; k++) begin put(1'b0, w[k], 1'b0, 1'b1); any |= coef_we || reg_we; end
    chk(!any, "R9 vertical hold no effect", any, 1'b0);
    put(1'b0, w[7], 1'b0, 1'b1);
    check_write(0, 0, 5, w, "R7 resume");

    // R8 + R9: vertical round load held, horizontal hold high throughout
    for (int k = 0; k < 8; k++) w[k] = wgen(12, k, 41);
    any = 0;
    put(1'b1, addr_word(2, 1, 12), 1'b1, 1'b0);
    put(1'b0, w[0], 1'b1, 1'b0);               any |= coef_we || reg_we;
    put(1'b0, 12'hF0F, 1'b1, 1'b1);            any |= coef_we || reg_we;
    put(1'b1, addr_word(4, 1, 2), 1'b0, 1'b1); any |= coef_we || reg_we;
    put(1'b0, w[1], 1'b1, 1'b0);               any |= coef_we || reg_we;
    put(1'b0, w[2], 1'b1, 1'b0);               any |= coef_we || reg_we;
    chk(!any, "R8 no write while held", any, 1'b0);
    put(1'b0, w[3], 1'b1, 1'b0);
    check_write(2, 1, 12, w, "R8 resume");

    // R7: horizontal address word ignored while idle and held
    put(1'b1, addr_word(1, 0, 4), 1'b1, 1'b0);
    put(1'b0, 12'h321, 1'b0, 1'b0);
    chk(!coef_we && !reg_we, "R7 idle address held", {coef_we, reg_we}, 2'b00);

    // R10: abort a round load with a configuration address
    for (int k = 0; k < 8; k++) w[k] = 12'h000;
    w[0] = 12'h5A5;
    any = 0;
    put(1'b1, addr_word(2, 0, 3), 1'b0, 1'b0);
    put(1'b0, 12'h011, 1'b0, 1'b0); any |= coef_we || reg_we;
    put(1'b0, 12'h022, 1'b0, 1'b0); any |= coef_we || reg_we;
    put(1'b1, addr_word(1, 0, 9), 1'b0, 1'b0); any |= coef_we || reg_we;
    chk(!any, "R10 aborted write dropped", any, 1'b0);
    put(1'b0, 12'h5A5, 1'b0, 1'b0);
    check_write(1, 0, 9, w, "R10 restart");

    // R10: abort into an invalid code returns to idle
    any = 0;
    put(1'b1, addr_word(4, 1, 1), 1'b0, 1'b0);
    put(1'b1, addr_word(6, 1, 1), 1'b0, 1'b0); any |= coef_we || reg_we;
    put(1'b0, 12'h0AA, 1'b0, 1'b0);            any |= coef_we || reg_we;
    put(1'b0, 12'h0BB, 1'b0, 1'b0);            any |= coef_we || reg_we;
    chk(!any, "R10 invalid restart idles", any, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule